// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Bypass

This block sits between up to 32 peripheral interrupt lines and a parent interrupt controller. It reduces the number of parent lines needed by grouping sources. Each grouped output has its own fixed mask that picks the sources it collects. A grouped output rises when any of its sources is both active and enabled. A separate forward mask picks sources that skip the grouping. Each of those drives its own dedicated output straight through, and no enable or status bit acts on it. This suits lines such as serial-port interrupts that the parent must see on their own.

Software sees two 32-bit words in an 8-byte window. The enable word sits at offset 0x0 and the status word at offset 0x4. No set-only or clear-only aliases exist, so software changes the enable word by reading it, modifying it and writing all 32 bits back. The status word shows the live level of each source that some grouped output uses. A build-time switch lets the grouped activity also raise a wake request toward the system.

Top module: `irq_agg_top`

## Requirements
- R1: After synchronous reset the enable word reads 0x00000000, and every grouped output and the wake output are low.
- R2: A write to offset 0x0 replaces all 32 enable bits with the written data. Writing 0xFFFFFFFF and then 0x00000001 reads back 0x00000001.
- R3: A read at offset 0x4 returns the current level of each source that is covered by some grouped mask and not by the forward mask. Every other bit reads 0. A read at any offset other than 0x0 and 0x4 returns 0.
- R4: A write to any offset other than 0x0, including 0x4, leaves the enable word unchanged.
- R5: Grouped output g is high in the cycle after a clock edge exactly when, at that edge, some source was high, enabled and set in mask g but not in the forward mask. With the default masks 0xEB8 and 0x140, output 0 collects sources 3, 4, 5, 7, 9, 10 and 11, and output 1 collects sources 6 and 8.
- R6: Bit i of the bypass output equals source i in the same cycle whenever bit i of the forward mask is set, whatever the enable word holds. Bits outside the forward mask are 0. With the default forward mask 0x7 this covers sources 0, 1 and 2.
- R7: Sources covered by no grouped mask and not by the forward mask (bits 12 to 31 by default) never raise any grouped, bypass or wake output.
- R8: With the wake switch on, the wake output is high exactly when any grouped output is high. With the switch off, the wake output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Source interrupt levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset within the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| grp_irq_o | output | NUM_GRP | Grouped outputs toward the parent controller |
| fwd_irq_o | output | 32 | Bypass outputs, one per forwarded source |
| wake_o | output | 1 | Wake request |

## Verification
A corrupted enable bit shows at the ports in one of two ways. A readback at offset 0x0 shows it at once. A grouped output that fails to follow its sources shows it one clock later, because the grouped outputs carry a single register stage. A wrong mask term either raises a grouped line from an unconnected or forwarded source or leaves the bypass bits differing from the sources in the same cycle. Sweeping each source alone across all 32 positions exposes this, and so does driving the upper unconnected bits all high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int SRC_W   = 32;
    localparam int MAX_GRP = 4;
    localparam int ADDR_W  = 3;

    typedef logic [SRC_W-1:0]               src_vec_t;
    typedef logic [MAX_GRP-1:0][SRC_W-1:0]  map_set_t;

    typedef enum logic [ADDR_W-1:0] {
        OFS_ENABLE = 3'h0,
        OFS_STATUS = 3'h4
    } reg_ofs_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        src_vec_t          wdata;
    } reg_req_t;

    // Mask of a group once forwarded sources are removed from it
    function automatic src_vec_t grp_eff(src_vec_t grp, src_vec_t fwd);
        return grp & ~fwd;
    endfunction

    // Union of all grouped masks in use, without the forwarded sources
    function automatic src_vec_t conn_mask(map_set_t maps, int ngrp, src_vec_t fwd);
        src_vec_t acc;
        acc = '0;
        for (int g = 0; g < MAX_GRP; g++) begin
            if (g < ngrp) acc = acc | maps[g];
        end
        return acc & ~fwd;
    endfunction

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter src_vec_t CONN = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req,
    input  src_vec_t src,
    output src_vec_t en_o,
    output src_vec_t rdata_o
);

    src_vec_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (req.we && (req.addr == OFS_ENABLE)) begin
            en_q <= req.wdata;
        end
    end

    always_comb begin
        case (req.addr)
            OFS_ENABLE: rdata_o = en_q;
            OFS_STATUS: rdata_o = src & CONN;
            default:    rdata_o = '0;
        endcase
    end

    assign en_o = en_q;

    a_r2_full_replace: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr == OFS_ENABLE) |=> (en_q == $past(req.wdata)));

    a_r4_other_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr != OFS_ENABLE) |=> $stable(en_q));

    a_r3_status_subset: assert property (@(posedge clk) disable iff (rst)
        (req.addr == OFS_STATUS) |-> ((rdata_o & ~src) == '0));

endmodule

// File: rtl/irq_agg_group.sv
module irq_agg_group
    import irq_agg_pkg::*;
#(
    parameter src_vec_t MASK = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src,
    input  src_vec_t en,
    output logic     irq_o
);

    logic hit;
    logic irq_q;

    assign hit = |(src & en & MASK);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= hit;
    end

    assign irq_o = irq_q;

    a_r5_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(src & en & MASK) != '0));

    a_r5_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_q) |-> ($past(src & en & MASK) == '0));

endmodule

// File: rtl/irq_agg_fwd.sv
module irq_agg_fwd
    import irq_agg_pkg::*;
#(
    parameter src_vec_t FWD = '0
) (
    input  src_vec_t src,
    output src_vec_t fwd_o
);

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        if (FWD[i]) begin : g_pass
            assign fwd_o[i] = src[i];
        end else begin : g_tie
            assign fwd_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int       NUM_GRP     = 2,
    parameter map_set_t MAP_MASKS   = {32'h0, 32'h0, 32'h0000_0140, 32'h0000_0EB8},
    parameter src_vec_t FWD_MASK    = 32'h0000_0007,
    parameter bit       WAKE_ENABLE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        src_i,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_GRP-1:0] grp_irq_o,
    output logic [31:0]        fwd_irq_o,
    output logic               wake_o
);

    localparam src_vec_t CONN = conn_mask(MAP_MASKS, NUM_GRP, FWD_MASK);

    reg_req_t req;
    src_vec_t en_w;

    assign req = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    irq_agg_regs #(.CONN(CONN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .src     (src_i),
        .en_o    (en_w),
        .rdata_o (reg_rdata)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        irq_agg_group #(.MASK(grp_eff(MAP_MASKS[g], FWD_MASK))) u_grp (
            .clk   (clk),
            .rst   (rst),
            .src   (src_i),
            .en    (en_w),
            .irq_o (grp_irq_o[g])
        );
    end

    irq_agg_fwd #(.FWD(FWD_MASK)) u_fwd (
        .src   (src_i),
        .fwd_o (fwd_irq_o)
    );

    if (WAKE_ENABLE) begin : g_wake
        assign wake_o = |grp_irq_o;
    end else begin : g_nowake
        assign wake_o = 1'b0;
    end

    a_r7_unconn_silent: assert property (@(posedge clk) disable iff (rst)
        (grp_irq_o != '0) |-> ($past(src_i & en_w & CONN) != '0));

    a_r8_wake_has_group: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (grp_irq_o != '0));

    a_r6_fwd_bits_only: assert property (@(posedge clk) disable iff (rst)
        ((fwd_irq_o & ~src_i) == '0));

endmodule

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NG         = 2;
    localparam logic [31:0] M0         = 32'h0000_0EB8;
    localparam logic [31:0] M1         = 32'h0000_0140;
    localparam logic [31:0] FWD        = 32'h0000_0007;
    localparam logic [31:0] CONN       = (M0 | M1) & ~FWD;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   src_i = '0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'h0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NG-1:0] grp_irq_o;
    logic [31:0]   fwd_irq_o;
    logic          wake_o;

    int total = 0;
    int bad   = 0;

    logic [31:0]   en_m  = '0;
    logic [NG-1:0] grp_m = '0;

    irq_agg_top #(
        .NUM_GRP     (NG),
        .MAP_MASKS   ({32'h0, 32'h0, M1, M0}),
        .FWD_MASK    (FWD),
        .WAKE_ENABLE (1'b1)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .grp_irq_o (grp_irq_o),
        .fwd_irq_o (fwd_irq_o),
        .wake_o    (wake_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [NG-1:0] calc_grp(logic [31:0] s, logic [31:0] e);
        logic [NG-1:0] r;
        r[0] = |(s & e & M0 & ~FWD);
        r[1] = |(s & e & M1 & ~FWD);
        return r;
    endfunction

    function automatic logic [31:0] calc_rd(logic [2:0] a, logic [31:0] s, logic [31:0] e);
        if (a == 3'h0) return e;
        if (a == 3'h4) return s & CONN;
        return '0;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    // One clock: combinational checks before the edge, registered checks after it
    task automatic cyc();
        #2;
        chk("R3 readback", reg_rdata, calc_rd(reg_addr, src_i, en_m));
        chk("R6 bypass", fwd_irq_o, src_i & FWD);
        @(posedge clk);
        grp_m = calc_grp(src_i, en_m);
        if (reg_we && reg_addr == 3'h0) en_m = reg_wdata;
        #1;
        chk("R5 grouped", {30'h0, grp_irq_o}, {30'h0, grp_m});
        chk("R8 wake", {31'h0, wake_o}, {31'h0, |grp_m});
    endtask

    task automatic drive(logic [31:0] s, logic we, logic [2:0] a, logic [31:0] d);
        src_i = s; reg_we = we; reg_addr = a; reg_wdata = d;
        cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        chk("R1 enable after reset", reg_rdata, 32'h0);
        chk("R1 grouped after reset", {30'h0, grp_irq_o}, 32'h0);
        chk("R1 wake after reset", {31'h0, wake_o}, 32'h0);
        drive(32'hFFFF_FFFF, 1'b0, 3'h0, '0);

        // R2 full replace of the enable word
        drive('0, 1'b1, 3'h0, 32'hFFFF_FFFF);
        drive('0, 1'b1, 3'h0, 32'h0000_0001);
        drive('0, 1'b0, 3'h0, '0);
        chk("R2 replace readback", reg_rdata, 32'h0000_0001);

        // R4 writes elsewhere ignored
        drive('0, 1'b1, 3'h0, 32'hFFFF_FFFF);
        drive('0, 1'b1, 3'h4, 32'h0);
        drive('0, 1'b1, 3'h2, 32'h0);
        drive('0, 1'b0, 3'h0, '0);
        chk("R4 enable kept", reg_rdata, 32'hFFFF_FFFF);

        // R3 status with all sources high
        drive(32'hFFFF_FFFF, 1'b0, 3'h4, '0);
        chk("R3 status all high", reg_rdata, 32'h0000_0FF8);

        // R5/R6 walk one source at a time
        for (int i = 0; i < 32; i++) begin
            drive(32'h1 << i, 1'b0, 3'h4, '0);
            drive(32'h0, 1'b0, 3'h4, '0);
        end

        // R7 unconnected sources never raise anything
        drive(32'hFFFF_F000, 1'b0, 3'h0, '0);
        drive(32'hFFFF_F000, 1'b0, 3'h4, '0);
        chk("R7 grouped silent", {30'h0, grp_irq_o}, 32'h0);
        chk("R7 bypass silent", fwd_irq_o, 32'h0);
        chk("R7 wake silent", {31'h0, wake_o}, 32'h0);

        // R6 bypass with enables cleared
        drive(32'h7, 1'b1, 3'h0, 32'h0);
        drive(32'h5, 1'b0, 3'h0, '0);
        chk("R6 bypass without enable", fwd_irq_o, 32'h5);

        // R5 disabled sources stay quiet, then enabling one lifts only its group
        drive(32'h0000_0140, 1'b0, 3'h0, '0);
        chk("R5 disabled group low", {30'h0, grp_irq_o}, 32'h0);
        drive(32'h0000_0140, 1'b1, 3'h0, 32'h0000_0100);
        drive(32'h0000_0140, 1'b0, 3'h0, '0);
        chk("R5 group1 only", {30'h0, grp_irq_o}, 32'h2);

        // Random mix
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] s;
            logic        w;
            logic [2:0]  a;
            s = $urandom;
            if (($urandom % 4) == 0) s = s & 32'h0000_0FFF;
            w = (($urandom % 5) == 0);
            a = 3'($urandom % 8);
            if (($urandom % 2) == 0) a = (($urandom % 2) == 0) ? 3'h0 : 3'h4;
            drive(s, w, a, $urandom);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule